// File: doc/BRIEF.md
# Oversampling UART Receiver with Error Flags

This block turns an asynchronous serial line into parallel bytes. The line idles high. A frame is a low start bit, eight data bits sent least significant bit first, one parity bit and one high stop bit. Each bit lasts sixteen periods of a baud tick input, a single-cycle pulse that a shared baud divider supplies at sixteen times the bit rate.

The serial input first passes through a synchroniser. A falling edge arms the receiver. The receiver then waits half a bit time and samples the line again to confirm that the start bit is real. After that it samples each later bit at its centre.

When the stop bit has been sampled, the receiver loads the byte into an output register and raises a ready flag. At the same moment it updates a parity-error flag and a framing-error flag. The host reads the result by pulling an active-low read strobe low. The strobe clears the ready flag and both error flags, and the byte stays on the output.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `rx_data` is 0 and `data_ready`, `parity_err` and `framing_err` are all low.
- R2: A frame starts only on a high-to-low transition of the synchronised line. If the line is back high when the eighth baud tick after that transition is sampled, the receiver drops the attempt. No flag changes and no byte is presented.
- R3: Data bits are sampled at the centre of each bit, every sixteen baud ticks after the confirmed mid-start sample. The first data bit received becomes bit 0 of `rx_data`.
- R4: When the stop bit has been sampled, `data_ready` goes high and `rx_data` holds the received byte.
- R5: Parity is even by default (parameter `PARITY_ODD` = 0). `parity_err` is set when the eight data bits plus the parity bit hold an odd number of ones. The byte is still presented.
- R6: `framing_err` is set when the line is low at the centre of the stop bit, the tenth bit position after the start bit.
- R7: `rd_n` low at a clock edge clears `data_ready`, `parity_err` and `framing_err`. `rx_data` keeps its value.
- R8: If a frame completes in the same cycle that `rd_n` is low, the completion wins. The new byte and flags are loaded, and `data_ready` is high for at least that cycle.
- R9: Each completed frame overwrites `rx_data` and both error flags, whether or not the previous result was read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Single-cycle pulse at sixteen times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rd_n | input | 1 | Active-low host read strobe |
| rx_data | output | 8 | Last received byte |
| data_ready | output | 1 | A byte is waiting to be read |
| parity_err | output | 1 | Parity of the last frame was wrong |
| framing_err | output | 1 | Stop bit of the last frame was low |

## Verification
Frame completion and the host read strobe can act in the same clock cycle. In that cycle one path tries to set the flags and the other tries to clear them.

The bench provokes this by leaving one byte unread and then holding `rd_n` low for the whole of the next frame. The completion cycle therefore always meets an active strobe. The bench watches `data_ready` at every falling clock edge. It passes the case only if the flag was seen high at least once and `rx_data` then holds the new byte.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  // Reset to the idle level so that leaving reset cannot look like a falling edge.
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 line,
  output logic                 done,
  output logic [DATA_BITS-1:0] word,
  output logic                 perr,
  output logic                 ferr
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(DATA_BITS + 1);
  localparam int HALF  = OVERSAMPLE / 2;

  rx_state_t            state;
  logic [CNT_W-1:0]     tcnt;
  logic [BIT_W-1:0]     bcnt;
  logic [DATA_BITS-1:0] shreg;
  logic                 par_q;
  logic                 line_q;
  logic                 full_bit;

  assign full_bit = tick && (tcnt == CNT_W'(OVERSAMPLE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RX_IDLE;
      tcnt   <= '0;
      bcnt   <= '0;
      shreg  <= '0;
      par_q  <= 1'b0;
      line_q <= 1'b1;
      done   <= 1'b0;
      perr   <= 1'b0;
      ferr   <= 1'b0;
    end else begin
      line_q <= line;
      done   <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (line_q && !line) begin
            state <= RX_START;
            tcnt  <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (tcnt == CNT_W'(HALF - 1)) begin
              tcnt  <= '0;
              bcnt  <= '0;
              state <= line ? RX_IDLE : RX_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        RX_DATA, RX_PAR, RX_STOP: begin
          if (tick) tcnt <= full_bit ? '0 : tcnt + 1'b1;
          if (full_bit) begin
            if (state == RX_DATA) begin
              shreg <= {line, shreg[DATA_BITS-1:1]};
              bcnt  <= bcnt + 1'b1;
              if (bcnt == BIT_W'(DATA_BITS - 1)) state <= RX_PAR;
            end else if (state == RX_PAR) begin
              par_q <= line;
              state <= RX_STOP;
            end else begin
              done  <= 1'b1;
              perr  <= ((^shreg) ^ par_q) != PARITY_ODD;
              ferr  <= ~line;
              state <= RX_IDLE;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign word = shreg;

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 done,
  input  logic [DATA_BITS-1:0] word,
  input  logic                 perr,
  input  logic                 ferr,
  input  logic                 rd_n,
  output logic [DATA_BITS-1:0] data_q,
  output logic                 ready_q,
  output logic                 perr_q,
  output logic                 ferr_q
);

  // A completing frame has priority over a read in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else if (done) begin
      data_q  <= word;
      ready_q <= 1'b1;
      perr_q  <= perr;
      ferr_q  <= ferr;
    end else if (!rd_n) begin
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit PARITY_ODD  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 baud_tick,
  input  logic                 rxd,
  input  logic                 rd_n,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 data_ready,
  output logic                 parity_err,
  output logic                 framing_err
);

  logic                 line_s;
  logic                 frame_done;
  logic [DATA_BITS-1:0] frame_word;
  logic                 frame_perr;
  logic                 frame_ferr;

  uart_rx_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (line_s)
  );

  uart_rx_fsm #(
    .DATA_BITS  (DATA_BITS),
    .OVERSAMPLE (OVERSAMPLE),
    .PARITY_ODD (PARITY_ODD)
  ) u_fsm (
    .clk  (clk),
    .rst  (rst),
    .tick (baud_tick),
    .line (line_s),
    .done (frame_done),
    .word (frame_word),
    .perr (frame_perr),
    .ferr (frame_ferr)
  );

  uart_rx_status #(
    .DATA_BITS (DATA_BITS)
  ) u_status (
    .clk     (clk),
    .rst     (rst),
    .done    (frame_done),
    .word    (frame_word),
    .perr    (frame_perr),
    .ferr    (frame_ferr),
    .rd_n    (rd_n),
    .data_q  (rx_data),
    .ready_q (data_ready),
    .perr_q  (parity_err),
    .ferr_q  (framing_err)
  );

endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_n,
  input logic                 frame_done,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 data_ready,
  input logic                 parity_err,
  input logic                 framing_err
);

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !frame_done) |=> (!data_ready && !parity_err && !framing_err));

  // R4
  done_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> data_ready);

  // R2
  ready_only_from_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_ready) |-> $past(frame_done));

  // R9
  data_held_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_done) |-> $stable(rx_data));

  // R5
  flags_need_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (parity_err || framing_err) |-> data_ready);

endmodule

bind uart_rx_core uart_rx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_n        (rd_n),
  .frame_done  (frame_done),
  .rx_data     (rx_data),
  .data_ready  (data_ready),
  .parity_err  (parity_err),
  .framing_err (framing_err)
);

// File: tb/tb_uart_rx_core.sv
`timescale 1ns/1ps
module tb_uart_rx_core;

  localparam int TDIV = 2;
  localparam int BITC = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       rd_n = 1'b1;
  logic [7:0] rx_data;
  logic       data_ready;
  logic       parity_err;
  logic       framing_err;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  ended  = 1'b0;
  bit  mon    = 1'b0;
  bit  seen   = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_core dut (
    .clk         (clk),
    .rst         (rst),
    .baud_tick   (baud_tick),
    .rxd         (rxd),
    .rd_n        (rd_n),
    .rx_data     (rx_data),
    .data_ready  (data_ready),
    .parity_err  (parity_err),
    .framing_err (framing_err)
  );

  initial begin
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  always @(negedge clk) if (mon && data_ready) seen = 1'b1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic par, input logic stp);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(par);
    drive_bit(stp);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read();
    rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rx_data", rx_data, 0);
    check("R1 data_ready", data_ready, 0);
    check("R1 parity_err", parity_err, 0);
    check("R1 framing_err", framing_err, 0);

    // R3 R4 R7: exhaustive sweep of all byte values with correct even parity
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = 8'(v);
      send(b, ^b, 1'b1);
      check("R3 rx_data", rx_data, v);
      check("R4 data_ready", data_ready, 1);
      check("R5 parity_err clean", parity_err, 0);
      check("R6 framing_err clean", framing_err, 0);
      do_read();
      check("R7 ready cleared", data_ready, 0);
      check("R7 data kept", rx_data, v);
    end

    // R5 parity error
    send(8'hA7, ~(^8'hA7), 1'b1);
    check("R5 parity_err", parity_err, 1);
    check("R5 framing_err", framing_err, 0);
    check("R5 byte", rx_data, 8'hA7);
    do_read();
    check("R7 parity cleared", parity_err, 0);

    // R6 framing error
    send(8'h3C, ^8'h3C, 1'b0);
    check("R6 framing_err", framing_err, 1);
    check("R6 parity_err", parity_err, 0);
    check("R6 ready", data_ready, 1);
    do_read();
    check("R7 framing cleared", framing_err, 0);

    // both errors, then R9 overwrite with a good frame without reading
    send(8'h81, ~(^8'h81), 1'b0);
    check("R5 both perr", parity_err, 1);
    check("R6 both ferr", framing_err, 1);
    send(8'h5A, ^8'h5A, 1'b1);
    check("R9 overwrite data", rx_data, 8'h5A);
    check("R9 perr overwritten", parity_err, 0);
    check("R9 ferr overwritten", framing_err, 0);
    check("R9 ready", data_ready, 1);
    do_read();

    // R2 short glitch rejected
    rxd = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    check("R2 glitch no ready", data_ready, 0);
    check("R2 glitch data kept", rx_data, 8'h5A);
    send(8'hC3, ^8'hC3, 1'b1);
    check("R2 recovers after glitch", rx_data, 8'hC3);
    check("R2 ready after glitch", data_ready, 1);

    // R8 completion wins over a read held low in the same cycle
    rd_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 held read clears", data_ready, 0);
    seen = 1'b0;
    mon  = 1'b1;
    send(8'h96, ^8'h96, 1'b1);
    mon  = 1'b0;
    check("R8 ready seen during read", seen, 1);
    check("R8 new byte", rx_data, 8'h96);
    check("R8 cleared afterwards", data_ready, 0);
    rd_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule